// File: doc/BRIEF.md
# Periodic Performance Report Frame Generator

This block turns line-quality events into a short unacknowledged link-layer frame and shifts it out one bit at a time. During each one-second interval it counts CRC errors and records whether framing-bit errors, severely errored framing, line code violations or slips occurred. At every second tick that interval is packed into a 16-bit status word and pushed onto a four-deep history.

A report frame carries the four most recent status words behind a fixed header. It is sent automatically at each tick when automatic mode is on, and once for every single-shot request. The serializer adds the opening and closing flags, a CRC-16 check sequence and zero-bit insertion. It emits one bit for each cycle in which the downstream bit slot is ready. Placing the bits into line time slots is left to the surrounding logic.

Top module: `pmr_frame_gen`

## Requirements
- R1: After synchronous reset `ser_vld` is 0, no frame is sent until one is requested, and all four history words are zero.
- R2: A frame is flag 0x7E, then an address octet {001110, C/R, 0} (bit 8..bit 1, with C/R taken from `cfg_cr` when the frame starts), then address octet 0x01, then control octet 0x03, then eight status octets, two check octets and flag 0x7E.
- R3: The status octets carry the history newest first (the interval just closed, then the three before it), two octets per interval. The first octet is bit8..bit1 = G3, LV, G4, U1, U2, G5, SL, G6. The second octet is bit8..bit1 = FE, SE, LB, G1, R, G2, Nm, Ni.
- R4: The CRC error count of an interval sets exactly one G bit: 1 gives G1, 2..5 gives G2, 6..10 gives G3, 11..100 gives G4, 101..319 gives G5 and 320 or more gives G6. A count of 0 leaves all G bits clear.
- R5: SE is set if a severely errored framing event occurred in the interval. FE is set for a framing bit error only when SE is clear. LV and SL are set by any line code violation or slip in the interval.
- R6: {Nm, Ni} holds a modulo-4 interval number that starts at 0 after reset and advances at every tick. U1, U2, R and LB copy `cfg_u1`, `cfg_u2`, `cfg_r` and `cfg_lb` at the tick that closes the interval.
- R7: Header and status octets go out bit 1 first. The check sequence is CRC-16 with polynomial 0x1021, preset to 0xFFFF and run over the header and status bits in transmit order. It is sent complemented, with the register's most significant bit first.
- R8: Between the flags, a 0 is inserted after every run of five 1s, including a run that ends on the last check bit. Flags are never stuffed.
- R9: Each cycle in which a frame is in progress and `bit_rdy` is high produces one bit; `ser_vld` is high for exactly one cycle, the cycle after that `bit_rdy`.
- R10: A tick with `auto_en` high, or a `shot_req` pulse, requests a frame. Requests that arrive while a frame is in progress are merged into one and served after the closing flag. With no request there is no output.
- R11: The CRC error counter saturates at 320. At a tick the counts and flags are latched and then cleared, and an event in the tick cycle itself counts toward the new interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_crc | input | 1 | One-cycle pulse per CRC error |
| ev_frm | input | 1 | Framing bit error event pulse |
| ev_sev | input | 1 | Severely errored framing event pulse |
| ev_lcv | input | 1 | Line code violation event pulse |
| ev_slip | input | 1 | Slip buffer slip event pulse |
| sec_tick | input | 1 | One-cycle pulse closing each one-second interval |
| auto_en | input | 1 | Send a report at every tick |
| shot_req | input | 1 | Pulse requesting a single report |
| bit_rdy | input | 1 | Downstream bit slot available this cycle |
| cfg_cr | input | 1 | C/R bit for the first address octet |
| cfg_u1 | input | 1 | Value for U1 |
| cfg_u2 | input | 1 | Value for U2 |
| cfg_r | input | 1 | Value for R |
| cfg_lb | input | 1 | Value for LB |
| ser_bit | output | 1 | Serial frame bit |
| ser_vld | output | 1 | `ser_bit` is valid this cycle |

## Verification
A wrong counter or flag inside the tally stays hidden until the next report. It then shows as one wrong G, FE/SE, LV or SL bit in the first status pair, and that bit stays wrong for three more reports as it moves down the history. A slip in the serializer's octet, bit or run counters usually shows within a few bits as a misplaced status bit or a missing stuff zero. It always shows at the check sequence, because all preceding bits feed the CRC. A fault in the request latch shows as a missing or extra `ser_vld` burst at the first idle cycle after the closing flag. The bench compares every bit and every `ser_vld` cycle with its model, so each of these faults is caught at the cycle it first reaches the ports.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

    localparam logic [7:0] FLAG_OCT   = 8'h7E;
    localparam logic [5:0] SAPI_VAL   = 6'b001110;
    localparam logic [7:0] UI_CTRL    = 8'h03;
    localparam logic [7:0] TEI_OCT    = 8'h01;
    localparam int         HDR_OCTETS = 3;
    localparam int         RUN_MAX    = 5;
    localparam logic [15:0] CRC_POLY  = 16'h1021;

    // bit 15 .. bit 0 = first octet bit8..bit1, second octet bit8..bit1
    typedef struct packed {
        logic g3, lv, g4, u1, u2, g5, sl, g6;
        logic fe, se, lb, g1, r,  g2, nm, ni;
    } stat_word_t;

    typedef struct packed {
        logic g6, g5, g4, g3, g2, g1;
    } grange_t;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPEN, PH_BODY, PH_FCS, PH_CLOSE
    } phase_t;

    function automatic grange_t crc_range(input logic [15:0] n);
        grange_t g;
        g = '0;
        if (n >= 16'd320)      g.g6 = 1'b1;
        else if (n >= 16'd101) g.g5 = 1'b1;
        else if (n >= 16'd11)  g.g4 = 1'b1;
        else if (n >= 16'd6)   g.g3 = 1'b1;
        else if (n >= 16'd2)   g.g2 = 1'b1;
        else if (n == 16'd1)   g.g1 = 1'b1;
        return g;
    endfunction

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/pmr_tally.sv
module pmr_tally
    import pmr_pkg::*;
#(
    parameter int CNT_MAX = 320,
    parameter int HIST    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sec_tick,
    input  logic                   ev_crc,
    input  logic                   ev_frm,
    input  logic                   ev_sev,
    input  logic                   ev_lcv,
    input  logic                   ev_slip,
    input  logic                   cfg_u1,
    input  logic                   cfg_u2,
    input  logic                   cfg_r,
    input  logic                   cfg_lb,
    output stat_word_t [HIST-1:0]  hist_o
);

    localparam int CW = $clog2(CNT_MAX + 1);

    logic [CW-1:0] cnt;
    logic          frm_f, sev_f, lcv_f, slip_f;
    logic [1:0]    seq;
    stat_word_t    cur;
    grange_t       g;

    always_comb begin
        g      = crc_range(16'(cnt));
        cur    = '0;
        cur.g1 = g.g1;
        cur.g2 = g.g2;
        cur.g3 = g.g3;
        cur.g4 = g.g4;
        cur.g5 = g.g5;
        cur.g6 = g.g6;
        cur.se = sev_f;
        cur.fe = frm_f & ~sev_f;
        cur.lv = lcv_f;
        cur.sl = slip_f;
        cur.u1 = cfg_u1;
        cur.u2 = cfg_u2;
        cur.r  = cfg_r;
        cur.lb = cfg_lb;
        cur.nm = seq[1];
        cur.ni = seq[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            frm_f  <= 1'b0;
            sev_f  <= 1'b0;
            lcv_f  <= 1'b0;
            slip_f <= 1'b0;
            seq    <= '0;
            hist_o <= '0;
        end else if (sec_tick) begin
            hist_o <= {hist_o[HIST-2:0], cur};
            cnt    <= CW'(ev_crc);
            frm_f  <= ev_frm;
            sev_f  <= ev_sev;
            lcv_f  <= ev_lcv;
            slip_f <= ev_slip;
            seq    <= seq + 2'd1;
        end else begin
            if (ev_crc && cnt != CW'(CNT_MAX))
                cnt <= cnt + CW'(1);
            frm_f  <= frm_f  | ev_frm;
            sev_f  <= sev_f  | ev_sev;
            lcv_f  <= lcv_f  | ev_lcv;
            slip_f <= slip_f | ev_slip;
        end
    end

    p_grange_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hist_o[0].g1, hist_o[0].g2, hist_o[0].g3,
                  hist_o[0].g4, hist_o[0].g5, hist_o[0].g6}));

    p_sev_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(hist_o[0].se && hist_o[0].fe));

    p_hist_shift_r3: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> (hist_o[1] == $past(hist_o[0])));

endmodule

// File: rtl/pmr_serial.sv
module pmr_serial
    import pmr_pkg::*;
#(
    parameter int HIST = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   cr_in,
    input  logic                   bit_rdy,
    input  stat_word_t [HIST-1:0]  hist_in,
    output logic                   ser_bit,
    output logic                   ser_vld,
    output logic                   busy
);

    localparam int BODY_N = HDR_OCTETS + 2 * HIST;
    localparam int OW     = $clog2(BODY_N);

    phase_t                  phase;
    logic [OW-1:0]           oct_idx;
    logic [2:0]              bit_idx;
    logic [2:0]              ones;
    logic [15:0]             crc;
    logic [HIST-1:0][15:0]   snap;
    logic                    cr_q;
    logic [7:0]              cur_oct;
    logic                    dbit;
    logic                    stuff;

    always_comb begin
        cur_oct = 8'h00;
        if (oct_idx == OW'(0))
            cur_oct = {SAPI_VAL, cr_q, 1'b0};
        else if (oct_idx == OW'(1))
            cur_oct = TEI_OCT;
        else if (oct_idx == OW'(2))
            cur_oct = UI_CTRL;
        else begin
            for (int k = 0; k < 2 * HIST; k++) begin
                if (oct_idx == OW'(k + HDR_OCTETS))
                    cur_oct = k[0] ? snap[k/2][7:0] : snap[k/2][15:8];
            end
        end
    end

    always_comb begin
        case (phase)
            PH_BODY:           dbit = cur_oct[bit_idx];
            PH_FCS:            dbit = ~crc[15];
            PH_OPEN, PH_CLOSE: dbit = FLAG_OCT[bit_idx];
            default:           dbit = 1'b0;
        endcase
    end

    assign stuff = (ones == 3'(RUN_MAX)) &&
                   (phase == PH_BODY || phase == PH_FCS ||
                    (phase == PH_CLOSE && bit_idx == 3'd0));
    assign busy  = (phase != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            oct_idx <= '0;
            bit_idx <= '0;
            ones    <= '0;
            crc     <= '1;
            snap    <= '0;
            cr_q    <= 1'b0;
            ser_bit <= 1'b0;
            ser_vld <= 1'b0;
        end else begin
            ser_vld <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    phase   <= PH_OPEN;
                    oct_idx <= '0;
                    bit_idx <= '0;
                    ones    <= '0;
                    crc     <= '1;
                    snap    <= hist_in;
                    cr_q    <= cr_in;
                end
            end else if (bit_rdy) begin
                ser_vld <= 1'b1;
                if (stuff) begin
                    ser_bit <= 1'b0;
                    ones    <= '0;
                end else begin
                    ser_bit <= dbit;
                    bit_idx <= bit_idx + 3'd1;
                    if (phase == PH_BODY || phase == PH_FCS)
                        ones <= dbit ? ones + 3'd1 : 3'd0;
                    if (phase == PH_BODY)
                        crc <= crc16_step(crc, dbit);
                    else if (phase == PH_FCS)
                        crc <= {crc[14:0], 1'b1};
                    if (bit_idx == 3'd7) begin
                        case (phase)
                            PH_OPEN: begin
                                phase   <= PH_BODY;
                                oct_idx <= '0;
                            end
                            PH_BODY: begin
                                if (oct_idx == OW'(BODY_N - 1)) begin
                                    phase   <= PH_FCS;
                                    oct_idx <= '0;
                                end else begin
                                    oct_idx <= oct_idx + OW'(1);
                                end
                            end
                            PH_FCS: begin
                                if (oct_idx == OW'(1))
                                    phase <= PH_CLOSE;
                                else
                                    oct_idx <= oct_idx + OW'(1);
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                end
            end
        end
    end

    p_vld_after_rdy_r9: assert property (@(posedge clk) disable iff (rst)
        ser_vld |-> $past(bit_rdy));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && $past(phase) == PH_IDLE) |-> !ser_vld);

endmodule

// File: rtl/pmr_frame_gen.sv
module pmr_frame_gen
    import pmr_pkg::*;
#(
    parameter int CNT_MAX = 320,
    parameter int HIST    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ev_crc,
    input  logic ev_frm,
    input  logic ev_sev,
    input  logic ev_lcv,
    input  logic ev_slip,
    input  logic sec_tick,
    input  logic auto_en,
    input  logic shot_req,
    input  logic bit_rdy,
    input  logic cfg_cr,
    input  logic cfg_u1,
    input  logic cfg_u2,
    input  logic cfg_r,
    input  logic cfg_lb,
    output logic ser_bit,
    output logic ser_vld
);

    stat_word_t [HIST-1:0] hist;
    logic                  busy;
    logic                  pend;
    logic                  start;

    assign start = pend && !busy;

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else
            pend <= (pend && !start) || (sec_tick && auto_en) || shot_req;
    end

    pmr_tally #(.CNT_MAX(CNT_MAX), .HIST(HIST)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .ev_crc   (ev_crc),
        .ev_frm   (ev_frm),
        .ev_sev   (ev_sev),
        .ev_lcv   (ev_lcv),
        .ev_slip  (ev_slip),
        .cfg_u1   (cfg_u1),
        .cfg_u2   (cfg_u2),
        .cfg_r    (cfg_r),
        .cfg_lb   (cfg_lb),
        .hist_o   (hist)
    );

    pmr_serial #(.HIST(HIST)) u_serial (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cr_in   (cfg_cr),
        .bit_rdy (bit_rdy),
        .hist_in (hist),
        .ser_bit (ser_bit),
        .ser_vld (ser_vld),
        .busy    (busy)
    );

    p_req_held_r10: assert property (@(posedge clk) disable iff (rst)
        (pend && busy) |=> pend);

endmodule

// File: tb/pmr_frame_gen_test.sv
module pmr_frame_gen_test;

    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_crc = 0, ev_frm = 0, ev_sev = 0, ev_lcv = 0, ev_slip = 0;
    logic sec_tick = 0, auto_en = 0, shot_req = 0, bit_rdy = 1;
    logic cfg_cr = 0, cfg_u1 = 0, cfg_u2 = 0, cfg_r = 0, cfg_lb = 0;
    logic ser_bit, ser_vld;

    int  checks = 0;
    int  bad = 0;
    bit  done = 0;
    bit  rdy_mode = 0;
    logic [7:0] lfsr = 8'hA5;

    always #(CLK_NS/2) clk = ~clk;

    pmr_frame_gen uut (
        .clk(clk), .rst(rst),
        .ev_crc(ev_crc), .ev_frm(ev_frm), .ev_sev(ev_sev),
        .ev_lcv(ev_lcv), .ev_slip(ev_slip),
        .sec_tick(sec_tick), .auto_en(auto_en), .shot_req(shot_req),
        .bit_rdy(bit_rdy), .cfg_cr(cfg_cr), .cfg_u1(cfg_u1),
        .cfg_u2(cfg_u2), .cfg_r(cfg_r), .cfg_lb(cfg_lb),
        .ser_bit(ser_bit), .ser_vld(ser_vld)
    );

    // ---------------- behavioural reference model ----------------
    int        m_cnt;
    bit        m_frm, m_sev, m_lcv, m_slip;
    bit [1:0]  m_seq;
    bit [15:0] m_hist [4];
    bit        m_pend, m_busy;
    bit        bq [$];
    string     tq [$];
    bit        exp_vld, exp_bit;
    string     exp_tag = "R9";

    function automatic bit [5:0] g_of(int n);
        bit [5:0] g = '0;
        if (n == 1)                  g[0] = 1;
        else if (n >= 2 && n <= 5)   g[1] = 1;
        else if (n >= 6 && n <= 10)  g[2] = 1;
        else if (n >= 11 && n <= 100) g[3] = 1;
        else if (n >= 101 && n <= 319) g[4] = 1;
        else if (n >= 320)           g[5] = 1;
        return g;
    endfunction

    function automatic bit [15:0] make_word();
        bit [5:0] g = g_of(m_cnt);
        bit se = m_sev;
        bit fe = m_frm && !m_sev;
        return {g[2], m_lcv, g[3], cfg_u1, cfg_u2, g[4], m_slip, g[5],
                fe, se, cfg_lb, g[0], cfg_r, g[1], m_seq[1], m_seq[0]};
    endfunction

    function automatic string stat_tag(bit second, int b);
        if (!second) begin
            if (b == 7 || b == 5 || b == 2 || b == 0) return "R3 R4 R11 G-code";
            if (b == 6 || b == 1) return "R3 R5 LV/SL";
            return "R3 R6 U-bits";
        end
        if (b == 4 || b == 2) return "R3 R4 R11 G-code";
        if (b == 7 || b == 6) return "R3 R5 FE/SE";
        return "R3 R6 LB/R/Nm/Ni";
    endfunction

    task automatic push_flag();
        bit [7:0] f = 8'h7E;
        for (int b = 0; b < 8; b++) begin
            bq.push_back(f[b]);
            tq.push_back("R2 flag");
        end
    endtask

    task automatic build_frame(bit cr);
        bit        raw [$];
        string     rtag [$];
        bit [7:0]  oct;
        bit [15:0] c = 16'hFFFF;
        int        ones = 0;
        for (int o = 0; o < 11; o++) begin
            if (o == 0)      oct = {6'b001110, cr, 1'b0};
            else if (o == 1) oct = 8'h01;
            else if (o == 2) oct = 8'h03;
            else if (((o - 3) % 2) == 0) oct = m_hist[(o - 3) / 2][15:8];
            else             oct = m_hist[(o - 3) / 2][7:0];
            for (int b = 0; b < 8; b++) begin
                raw.push_back(oct[b]);
                if (o < 3) rtag.push_back("R2 R7 header");
                else       rtag.push_back(stat_tag(((o - 3) % 2) == 1, b));
            end
        end
        foreach (raw[i]) begin
            bit fb = c[15] ^ raw[i];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        for (int i = 15; i >= 0; i--) begin
            raw.push_back(~c[i]);
            rtag.push_back("R7 check sequence");
        end
        push_flag();
        foreach (raw[i]) begin
            bq.push_back(raw[i]);
            tq.push_back(rtag[i]);
            ones = raw[i] ? ones + 1 : 0;
            if (ones == 5) begin
                bq.push_back(1'b0);
                tq.push_back("R8 stuffed zero");
                ones = 0;
            end
        end
        push_flag();
    endtask

    always @(posedge clk) begin : model
        bit        st;
        bit        trig;
        bit [15:0] w;
        if (rst) begin
            m_cnt = 0; m_frm = 0; m_sev = 0; m_lcv = 0; m_slip = 0;
            m_seq = 0; m_pend = 0; m_busy = 0; exp_vld = 0; exp_bit = 0;
            for (int i = 0; i < 4; i++) m_hist[i] = '0;
            bq.delete(); tq.delete();
        end else begin
            st = 0;
            exp_vld = 0;
            if (m_busy) begin
                if (bit_rdy) begin
                    exp_vld = 1;
                    exp_bit = bq.pop_front();
                    exp_tag = tq.pop_front();
                    if (bq.size() == 0) m_busy = 0;
                end
            end else if (m_pend) begin
                build_frame(cfg_cr);
                m_busy = 1;
                st = 1;
            end
            trig   = (sec_tick && auto_en) || shot_req;
            m_pend = (m_pend && !st) || trig;
            if (sec_tick) begin
                w = make_word();
                for (int i = 3; i > 0; i--) m_hist[i] = m_hist[i-1];
                m_hist[0] = w;
                m_cnt  = ev_crc ? 1 : 0;
                m_frm  = ev_frm; m_sev = ev_sev; m_lcv = ev_lcv; m_slip = ev_slip;
                m_seq  = m_seq + 1;
            end else begin
                if (ev_crc && m_cnt < 320) m_cnt = m_cnt + 1;
                m_frm  = m_frm  | ev_frm;
                m_sev  = m_sev  | ev_sev;
                m_lcv  = m_lcv  | ev_lcv;
                m_slip = m_slip | ev_slip;
            end
        end
    end

    // ---------------- comparison every clock ----------------
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (ser_vld !== exp_vld) begin
                bad++;
                $display("FAIL %s ser_vld actual=%0b expected=%0b at %0t",
                         exp_vld ? "R9" : "R10", ser_vld, exp_vld, $time);
            end else if (exp_vld) begin
                checks++;
                if (ser_bit !== exp_bit) begin
                    bad++;
                    $display("FAIL %s ser_bit actual=%0b expected=%0b at %0t",
                             exp_tag, ser_bit, exp_bit, $time);
                end
            end
        end
    end

    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        bit_rdy <= rdy_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // ---------------- stimulus ----------------
    task automatic report();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    task automatic crc_errs(int n);
        for (int i = 0; i < n; i++) begin
            ev_crc = 1;
            @(negedge clk);
            ev_crc = 0;
        end
    endtask

    task automatic pulse(bit f, bit s, bit l, bit p);
        ev_frm = f; ev_sev = s; ev_lcv = l; ev_slip = p;
        @(negedge clk);
        ev_frm = 0; ev_sev = 0; ev_lcv = 0; ev_slip = 0;
    endtask

    task automatic tick(bit with_crc);
        sec_tick = 1;
        ev_crc   = with_crc;
        @(negedge clk);
        sec_tick = 0;
        ev_crc   = 0;
    endtask

    task automatic shot();
        shot_req = 1;
        @(negedge clk);
        shot_req = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy || m_pend);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            report();
        end
    end

    initial begin : main
        int cnts [12] = '{1, 5, 6, 10, 11, 100, 101, 319, 320, 400, 2, 0};
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: quiet after reset
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            checks++;
            if (ser_vld !== 1'b0) begin
                bad++;
                $display("FAIL R1 idle ser_vld actual=%0b expected=0", ser_vld);
            end
        end
        // single shot with empty history (R1, R2, R7)
        shot();
        wait_idle();
        // one interval with auto mode off: tick must not send (R10)
        cfg_cr = 1;
        crc_errs(1);
        pulse(0, 0, 1, 0);
        tick(0);
        repeat (30) @(negedge clk);
        shot();
        wait_idle();
        // range boundaries, saturation, flags, throttled bit slots (R4 R5 R6 R11 R9)
        rdy_mode = 1;
        auto_en  = 1;
        for (int i = 0; i < 12; i++) begin
            cfg_u1 = i[0]; cfg_u2 = i[1]; cfg_r = i[2]; cfg_lb = i[0] ^ i[1];
            cfg_cr = i[1];
            crc_errs(cnts[i]);
            pulse(i % 3 == 0, i % 4 == 1, i % 2 == 0, i % 5 == 2);
            if (i == 4) pulse(1, 1, 0, 0);
            if (i == 7) shot();
            tick(i == 5);
            repeat (10) @(negedge clk);
        end
        auto_en = 0;
        wait_idle();
        // requests during a frame collapse into one (R10)
        shot();
        repeat (20) @(negedge clk);
        shot();
        tick(0);
        shot();
        wait_idle();
        checks++;
        if (bq.size() != 0 || m_busy) begin
            bad++;
            $display("FAIL R10 leftover bits actual=%0d expected=0", bq.size());
        end
        report();
    end

endmodule